// File: doc/BRIEF.md
# Multi-Master Semaphore Bank

This block is a bank of hardware semaphores shared by several processors on one chip. Each processor reaches the bank through its own register port: a byte address, a write strobe, 32-bit write data and a 4-bit master identifier that travels with every access. Read data comes back combinationally from the address on the same port. A master asks for a semaphore by writing its own identifier into that semaphore's register. It then reads the register back, and it holds the semaphore only if the low nibble shows its identifier. It gives the semaphore up by writing zero.

Each release raises a per-semaphore event flag. Software reads these flags at the flag register and clears them by writing a mask to the same offset. A one-bit control register at offset 0x00 selects the handshake protocol. Zero selects the polled protocol, which uses no interrupts. When several ports write in the same cycle, the port with the lowest index takes priority.

Top module: `sem_bank`

## Requirements
- R1: The bank holds NUM_SEM (default 32) semaphores. Semaphore i is at byte offset 0x08 + 4*i. A read returns the owner ID in bits [3:0] and zero in every higher bit. Owner 0 means free.
- R2: A write to a free semaphore takes effect when bits [3:0] of the data equal the writer's nonzero master ID. The higher data bits are ignored. The writer then becomes the owner, and reads show it from the cycle after the write.
- R3: A write to a semaphore that already has an owner leaves the owner unchanged unless it is a release. A write to a free semaphore is ignored when its low nibble differs from the writer's ID or when the writer's ID is 0.
- R4: The owner frees a semaphore by writing a value whose low nibble is 0. The same write from any other master ID is ignored.
- R5: When several ports make valid claims on the same free semaphore in one cycle, the lowest-indexed port with a valid claim wins. The other claims are dropped.
- R6: The control register at 0x00 stores bit 0 of the written data. It reads back in bit 0, with zeros above. When several ports write it in the same cycle, the lowest-indexed port wins.
- R7: Each release sets flag i of the flag register at 0x90. The flag is visible from the cycle after the release.
- R8: A write to 0x90 clears every flag whose data bit is 1. Writing all ones clears every flag. A release in the same cycle as a clear of the same flag leaves the flag set. When several ports write 0x90 in the same cycle, their masks combine.
- R9: After reset every semaphore is free, the control register is 0 and no flag is set.
- R10: A read of any other offset returns 0, including misaligned offsets and offsets past the last semaphore. A write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | NUM_PORTS*ADDR_W | Byte address per port |
| we_i | input | NUM_PORTS | Write strobe per port |
| wdata_i | input | NUM_PORTS*DATA_W | Write data per port |
| mid_i | input | NUM_PORTS*ID_W | Master ID of the access on each port |
| rdata_o | output | NUM_PORTS*DATA_W | Combinational read data per port |

## Verification
Some properties are checked on every cycle: an owned semaphore can only keep its owner or become free, every release leaves its flag raised, reads of semaphore registers carry nothing above the ID nibble, and unmapped or control reads keep their zero bits. Other behaviours can only be shown by the bench's scenarios. These include which master wins a same-cycle contest, ignored claims with a mismatched nibble or a zero ID, release attempts by a non-owner, partial flag clears and a clear that collides with a release. The bench also runs a random mix of accesses against a reference model that is compared every clock.

// File: rtl/sem_bank_pkg.sv
`timescale 1ns/1ps
package sem_bank_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_CTRL = 2'd1,
      ACC_SEM  = 2'd2,
      ACC_FLAG = 2'd3
   } acc_kind_e;

   typedef struct packed {
      acc_kind_e  kind;
      logic [7:0] idx;
   } acc_dec_t;

   function automatic acc_dec_t decode_addr(input logic [31:0] addr,
                                            input int unsigned num_sem,
                                            input int unsigned ctrl_off,
                                            input int unsigned sem_base,
                                            input int unsigned flag_off);
      acc_dec_t r;
      r.kind = ACC_NONE;
      r.idx  = '0;
      if (addr == ctrl_off) begin
         r.kind = ACC_CTRL;
      end else if (addr == flag_off) begin
         r.kind = ACC_FLAG;
      end else if (addr >= sem_base && addr < sem_base + 4 * num_sem &&
                   addr[1:0] == 2'b00) begin
         r.kind = ACC_SEM;
         r.idx  = 8'((addr - sem_base) >> 2);
      end
      return r;
   endfunction

endpackage

// File: rtl/sem_cell.sv
`timescale 1ns/1ps
module sem_cell #(
   parameter int NUM_PORTS = 2,
   parameter int ID_W      = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PORTS-1:0]      hit_i,
   input  logic [NUM_PORTS*ID_W-1:0] wnib_i,
   input  logic [NUM_PORTS*ID_W-1:0] mid_i,
   output logic [ID_W-1:0]           owner_o,
   output logic                      release_o
);
   logic [ID_W-1:0] own_q, own_nxt;
   logic            rel;
   logic            taken;

   always_comb begin
      own_nxt = own_q;
      rel     = 1'b0;
      taken   = 1'b0;
      if (own_q == '0) begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (!taken && hit_i[p] &&
                wnib_i[p*ID_W +: ID_W] == mid_i[p*ID_W +: ID_W] &&
                mid_i[p*ID_W +: ID_W] != '0) begin
               own_nxt = mid_i[p*ID_W +: ID_W];
               taken   = 1'b1;
            end
         end
      end else begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit_i[p] && wnib_i[p*ID_W +: ID_W] == '0 &&
                mid_i[p*ID_W +: ID_W] == own_q) begin
               own_nxt = '0;
               rel     = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_q <= '0;
      else        own_q <= own_nxt;
   end

   assign owner_o   = own_q;
   assign release_o = rel;
endmodule

// File: rtl/sem_flags.sv
`timescale 1ns/1ps
module sem_flags #(
   parameter int NUM_SEM = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SEM-1:0] set_i,
   input  logic [NUM_SEM-1:0] clr_i,
   output logic [NUM_SEM-1:0] flags_o
);
   logic [NUM_SEM-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/sem_rd_mux.sv
`timescale 1ns/1ps
module sem_rd_mux
   import sem_bank_pkg::*;
#(
   parameter int NUM_SEM = 32,
   parameter int ID_W    = 4,
   parameter int DATA_W  = 32
) (
   input  acc_dec_t                  dec_i,
   input  logic [NUM_SEM*ID_W-1:0]   owners_i,
   input  logic                      ctrl_i,
   input  logic [NUM_SEM-1:0]        flags_i,
   output logic [DATA_W-1:0]         rdata_o
);
   always_comb begin
      rdata_o = '0;
      unique case (dec_i.kind)
         ACC_CTRL: rdata_o = DATA_W'(ctrl_i);
         ACC_SEM:  rdata_o = DATA_W'(owners_i[int'(dec_i.idx)*ID_W +: ID_W]);
         ACC_FLAG: rdata_o = DATA_W'(flags_i);
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/sem_bank.sv
`timescale 1ns/1ps
module sem_bank
   import sem_bank_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int NUM_SEM   = 32,
   parameter int ID_W      = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CTRL_OFF  = 'h00,
   parameter int SEM_BASE  = 'h08,
   parameter int FLAG_OFF  = 'h90
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
   input  logic [NUM_PORTS-1:0]        we_i,
   input  logic [NUM_PORTS*DATA_W-1:0] wdata_i,
   input  logic [NUM_PORTS*ID_W-1:0]   mid_i,
   output logic [NUM_PORTS*DATA_W-1:0] rdata_o
);
   localparam int SEM_END = SEM_BASE + 4 * NUM_SEM;

   if (NUM_SEM < 1 || NUM_SEM > DATA_W || NUM_SEM > 256) begin : g_bad_num
      $error("sem_bank: NUM_SEM must lie in 1..min(DATA_W,256)");
   end
   if (ID_W < 1 || ID_W >= DATA_W) begin : g_bad_id
      $error("sem_bank: ID_W must be below DATA_W");
   end
   if (ADDR_W > 32 || SEM_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("sem_bank: semaphore window exceeds the address space");
   end
   if (FLAG_OFF >= SEM_BASE && FLAG_OFF < SEM_END) begin : g_bad_flag
      $error("sem_bank: flag register overlaps the semaphore window");
   end
   if (CTRL_OFF >= SEM_BASE && CTRL_OFF < SEM_END) begin : g_bad_ctrl
      $error("sem_bank: control register overlaps the semaphore window");
   end

   acc_dec_t                  dec [NUM_PORTS];
   logic [NUM_SEM*ID_W-1:0]   owner_flat;
   logic [NUM_SEM-1:0]        rel_vec;
   logic [NUM_SEM-1:0]        clr_vec;
   logic [NUM_SEM-1:0]        flags_q;
   logic [NUM_PORTS*ID_W-1:0] wnib;
   logic                      ctrl_q, ctrl_nxt;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_comb dec[p] = decode_addr(32'(addr_i[p*ADDR_W +: ADDR_W]),
                                       NUM_SEM, CTRL_OFF, SEM_BASE, FLAG_OFF);
      assign wnib[p*ID_W +: ID_W] = wdata_i[p*DATA_W +: ID_W];

      sem_rd_mux #(.NUM_SEM(NUM_SEM), .ID_W(ID_W), .DATA_W(DATA_W)) u_rd (
         .dec_i   (dec[p]),
         .owners_i(owner_flat),
         .ctrl_i  (ctrl_q),
         .flags_i (flags_q),
         .rdata_o (rdata_o[p*DATA_W +: DATA_W])
      );
   end

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
      logic [NUM_PORTS-1:0] hit;
      always_comb begin
         for (int p = 0; p < NUM_PORTS; p++)
            hit[p] = we_i[p] && dec[p].kind == ACC_SEM && int'(dec[p].idx) == i;
      end

      sem_cell #(.NUM_PORTS(NUM_PORTS), .ID_W(ID_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit_i    (hit),
         .wnib_i   (wnib),
         .mid_i    (mid_i),
         .owner_o  (owner_flat[i*ID_W +: ID_W]),
         .release_o(rel_vec[i])
      );
   end

   always_comb begin
      clr_vec = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         if (we_i[p] && dec[p].kind == ACC_FLAG)
            clr_vec = clr_vec | wdata_i[p*DATA_W +: NUM_SEM];
   end

   sem_flags #(.NUM_SEM(NUM_SEM)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rel_vec),
      .clr_i  (clr_vec),
      .flags_o(flags_q)
   );

   always_comb begin
      ctrl_nxt = ctrl_q;
      for (int p = NUM_PORTS - 1; p >= 0; p--)
         if (we_i[p] && dec[p].kind == ACC_CTRL)
            ctrl_nxt = wdata_i[p*DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= 1'b0;
      else        ctrl_q <= ctrl_nxt;
   end
endmodule

// File: rtl/sem_bank_chk.sv
`timescale 1ns/1ps
module sem_bank_chk #(
   parameter int NUM_PORTS = 2,
   parameter int NUM_SEM   = 32,
   parameter int ID_W      = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CTRL_OFF  = 'h00,
   parameter int SEM_BASE  = 'h08,
   parameter int FLAG_OFF  = 'h90
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_PORTS*ADDR_W-1:0] addr_i,
   input logic [NUM_PORTS*DATA_W-1:0] rdata_o,
   input logic [NUM_SEM*ID_W-1:0]     owner_flat,
   input logic [NUM_SEM-1:0]          flags
);
   for (genvar i = 0; i < NUM_SEM; i++) begin : g_s
      AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n) // R3
         (owner_flat[i*ID_W +: ID_W] != '0) |=>
         (owner_flat[i*ID_W +: ID_W] == $past(owner_flat[i*ID_W +: ID_W]) ||
          owner_flat[i*ID_W +: ID_W] == '0));
      AST_RELEASE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) // R7
         (owner_flat[i*ID_W +: ID_W] != '0) |=>
         (owner_flat[i*ID_W +: ID_W] != '0 || flags[i]));
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      int unsigned a;
      logic        in_sem, mapped;
      always_comb begin
         a      = 32'(addr_i[p*ADDR_W +: ADDR_W]);
         in_sem = a >= SEM_BASE && a < SEM_BASE + 4 * NUM_SEM && a[1:0] == 2'b00;
         mapped = in_sem || a == CTRL_OFF || a == FLAG_OFF;
      end
      AST_SEM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) // R1
         in_sem |-> rdata_o[p*DATA_W + ID_W +: DATA_W - ID_W] == '0);
      AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) // R10
         !mapped |-> rdata_o[p*DATA_W +: DATA_W] == '0);
      AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) // R6
         (a == CTRL_OFF) |-> rdata_o[p*DATA_W + 1 +: DATA_W - 1] == '0);
   end
endmodule

bind sem_bank sem_bank_chk #(
   .NUM_PORTS(NUM_PORTS), .NUM_SEM(NUM_SEM), .ID_W(ID_W), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF), .SEM_BASE(SEM_BASE), .FLAG_OFF(FLAG_OFF)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_i    (addr_i),
   .rdata_o   (rdata_o),
   .owner_flat(owner_flat),
   .flags     (flags_q)
);

// File: tb/sim_sem_bank.sv
`timescale 1ns/1ps
module sim_sem_bank;
   localparam int P  = 2;
   localparam int N  = 32;
   localparam int IW = 4;
   localparam int AW = 8;
   localparam int DW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [P*AW-1:0]   addr = '0;
   logic [P-1:0]      we = '0;
   logic [P*DW-1:0]   wdata = '0;
   logic [P*IW-1:0]   mid = '0;
   logic [P*DW-1:0]   rdata;

   int          m_own [N];
   bit          m_ctrl;
   bit [31:0]   m_flags;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   sem_bank u0 (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we),
      .wdata_i(wdata), .mid_i(mid), .rdata_o(rdata)
   );

   task automatic drv(int p, int a, bit w, logic [31:0] d, int id);
      addr[p*AW +: AW]  = AW'(a);
      we[p]             = w;
      wdata[p*DW +: DW] = d;
      mid[p*IW +: IW]   = IW'(id);
   endtask

   task automatic idle();
      we = '0;
   endtask

   function automatic logic [31:0] model_read(int a);
      if (a == 'h00) return {31'b0, m_ctrl};
      if (a == 'h90) return m_flags;
      if (a >= 8 && a < 8 + 4 * N && a % 4 == 0) return 32'(m_own[(a - 8) / 4]);
      return 32'h0;
   endfunction

   task automatic model_update();
      int        nown [N];
      bit [31:0] setv = '0;
      bit [31:0] clrv = '0;
      bit        cdone = 1'b0;
      for (int i = 0; i < N; i++) begin
         nown[i] = m_own[i];
         for (int p = 0; p < P; p++) begin
            int a  = int'(addr[p*AW +: AW]);
            int id = int'(mid[p*IW +: IW]);
            int nb = int'(wdata[p*DW +: 4]);
            if (we[p] && a == 8 + 4 * i) begin
               if (m_own[i] == 0 && nown[i] == 0 && id != 0 && nb == id)
                  nown[i] = id;
               else if (m_own[i] != 0 && nb == 0 && id == m_own[i]) begin
                  nown[i] = 0;
                  setv[i] = 1'b1;
               end
            end
         end
      end
      for (int p = 0; p < P; p++) begin
         int a = int'(addr[p*AW +: AW]);
         if (we[p] && a == 'h00 && !cdone) begin
            m_ctrl = wdata[p*DW];
            cdone  = 1'b1;
         end
         if (we[p] && a == 'h90) clrv = clrv | wdata[p*DW +: DW];
      end
      m_flags = (m_flags & ~clrv) | setv;
      for (int i = 0; i < N; i++) m_own[i] = nown[i];
   endtask

   // Inputs are already applied after a falling edge; compare, then advance.
   task automatic step(string tag);
      #1;
      for (int p = 0; p < P; p++) begin
         int          a   = int'(addr[p*AW +: AW]);
         logic [31:0] exp = model_read(a);
         logic [31:0] got = rdata[p*DW +: DW];
         n_cmp++;
         if (got !== exp) begin
            n_bad++;
            $display("FAIL %s port %0d addr %h: got %h expected %h", tag, p, a, got, exp);
         end
      end
      model_update();
      @(negedge clk);
   endtask

   task automatic rd2(string tag, int a0, int a1);
      idle();
      drv(0, a0, 0, 0, 0);
      drv(1, a1, 0, 0, 0);
      step(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_own[i] = 0;
      m_ctrl = 0; m_flags = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      rd2("R9", 'h00, 'h90);
      rd2("R9", 'h08, 'h84);

      // R2: claim sem 5 by ID 3, read from both ports
      idle(); drv(0, 'h1C, 1, 32'h3, 3); drv(1, 'h1C, 0, 0, 0); step("R2");
      rd2("R2", 'h1C, 'h1C);

      // R3: claim on owned semaphore, and mismatched nibble on free one
      idle(); drv(1, 'h1C, 1, 32'h7, 7); step("R3");
      rd2("R3", 'h1C, 'h1C);
      idle(); drv(1, 'h20, 1, 32'h5, 7); step("R3");
      rd2("R3", 'h20, 'h20);
      idle(); drv(0, 'h24, 1, 32'h0, 0); step("R3");
      rd2("R3", 'h24, 'h90);

      // R4: non-owner release ignored, owner release frees
      idle(); drv(1, 'h1C, 1, 32'h0, 7); step("R4");
      rd2("R4", 'h1C, 'h90);
      idle(); drv(0, 'h1C, 1, 32'hFFFF_FFF0, 3); step("R4");
      rd2("R4", 'h1C, 'h1C);
      // R7: flag for sem 5
      rd2("R7", 'h90, 'h1C);

      // R5: same-cycle contention
      idle(); drv(0, 'h2C, 1, 32'h2, 2); drv(1, 'h2C, 1, 32'h6, 6); step("R5");
      rd2("R5", 'h2C, 'h2C);
      idle(); drv(0, 'h30, 1, 32'h9, 2); drv(1, 'h30, 1, 32'h6, 6); step("R5");
      rd2("R5", 'h30, 'h30);

      // R1: upper write bits ignored, read shows nibble only; last semaphore
      idle(); drv(0, 'h84, 1, 32'hABCD_0004, 4); step("R1");
      rd2("R1", 'h84, 'h80);

      // R6: control register
      idle(); drv(0, 'h00, 1, 32'hFFFF_FFFF, 1); step("R6");
      rd2("R6", 'h00, 'h00);
      idle(); drv(0, 'h00, 1, 32'h0, 1); drv(1, 'h00, 1, 32'h1, 2); step("R6");
      rd2("R6", 'h00, 'h00);

      // R8: partial clear, release colliding with clear, full clear
      idle(); drv(0, 'h2C, 1, 32'h0, 2); step("R8");
      rd2("R8", 'h90, 'h2C);
      idle(); drv(1, 'h90, 1, 32'h0000_0020, 1); step("R8");
      rd2("R8", 'h90, 'h1C);
      idle(); drv(0, 'h84, 1, 32'h0, 4); drv(1, 'h90, 1, 32'hFFFF_FFFF, 1); step("R8");
      rd2("R8", 'h90, 'h84);
      idle(); drv(0, 'h90, 1, 32'h0000_FFFF, 1); drv(1, 'h90, 1, 32'hFFFF_0000, 1); step("R8");
      rd2("R8", 'h90, 'h90);

      // R10: unmapped reads and writes
      idle(); drv(0, 'h04, 1, 32'hFFFF_FFFF, 1); drv(1, 'h09, 1, 32'h1, 1); step("R10");
      rd2("R10", 'h04, 'h09);
      rd2("R10", 'h88, 'hFC);
      rd2("R10", 'h00, 'h08);

      // R2: random mix against the reference model
      for (int k = 0; k < 400; k++) begin
         idle();
         for (int p = 0; p < P; p++) begin
            int sel = $urandom_range(0, 9);
            int a;
            int id  = $urandom_range(0, 3);
            logic [31:0] d;
            if (sel < 7)       a = 8 + 4 * $urandom_range(0, 3);
            else if (sel == 7) a = 'h90;
            else if (sel == 8) a = 'h00;
            else               a = $urandom_range(0, 255);
            d = ($urandom_range(0, 2) == 0) ? 32'($urandom) & 32'hFFFF_FFF0
                                            : (32'($urandom) & 32'hFFFF_FFF0) | 32'(id);
            drv(p, a, 1'($urandom_range(0, 1)), d, id);
         end
         step("R2");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule